// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns words from a valid/ready stream into asynchronous serial frames on one output line. That line sits high when idle. Each frame has the following parts, in order:

- a start bit of 0;
- 7, 8 or 9 data bits, least significant bit first;
- an optional extra bit, which is either parity or a multi-processor marker;
- one or two stop bits of 1.

A byte-wide mode register sets the frame format and the clock prescaler. Software writes it through a plain write strobe. A write is accepted only while both the transmit enable and the receive enable are low.

The duration of one bit is set by two things: the prescaler division selected in the mode register, and the bit-rate count on the `bit_rate` input. The stream interface follows the usual back-pressure rules. A word transfers on a rising clock edge where `s_valid` and `s_ready` are both high. The producer holds `s_data` and `s_mark` stable while `s_valid` is high and `s_ready` is low. `s_ready` is high only while the transmitter is idle and transmit is enabled. A busy transmitter therefore stalls the producer for the whole frame. The frame begins in the cycle after the transfer.

Mode register layout:

| Bit | Field | Meaning |
|-----|-------|---------|
| 0 | `stop2` | 1 selects two stop bits |
| 1 | `par_odd` | 1 selects odd parity |
| 2 | `par_en` | 1 appends a parity bit |
| 3 | `mp_en` | 1 enables multi-processor marking |
| 4 | `len_bit` | frame length select |
| 6:5 | `clk_sel` | prescaler code |
| 7 | reserved | stored, no effect |

Top module: `serial_frame_tx`

## Requirements
- R1: After reset all eight mode bits are 0, `txd` is 1 and no frame is in progress. With `len_ext`=1, the reset mode gives 8 data bits, no extra bit, one stop bit and a divide-by-1 prescaler.
- R2: The prescaler code (bits 6:5) divides the clock by 1, 4, 16 or 64 for codes 0, 1, 2 and 3. Every frame bit lasts that divisor times (`bit_rate`+1) clock cycles.
- R3: The length code `{len_ext, len_bit}` selects the data length. Codes 00 and 01 give 9 data bits, 10 gives 8 and 11 gives 7.
- R4: Data bits leave least significant first, starting from `s_data[0]`. Data bits beyond the selected length are not transmitted; in 7-bit mode that means `s_data[8:7]` are dropped.
- R5: Bit 0 of the mode register picks the stop bits: 0 gives one stop bit and 1 gives two. The frame ends with the stop bits, after which the line idles high.
- R6: With `par_en` (bit 2) set and `mp_en` clear, a parity bit follows the data. It is even parity over the transmitted data bits when `par_odd` (bit 1) is 0, and odd parity when it is 1.
- R7: With `mp_en` (bit 3) set, the bit after the data is the `s_mark` value captured at the transfer, whatever `par_en` and `par_odd` hold.
- R8: A mode write is discarded whenever `tx_en` or `rx_en` is 1. Later frames keep the earlier format.
- R9: `s_ready` is 1 only when the transmitter is idle and `tx_en` is 1. After a transfer, `txd` shows the start bit 0 in the next cycle. Data and mark are captured at the transfer, so later changes on those inputs have no effect on the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write value |
| len_ext | input | 1 | Length extension bit, upper bit of the length code |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable, used only for the write lock |
| bit_rate | input | 8 | Bit-rate count; a bit lasts prescale*(bit_rate+1) cycles |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word ready |
| s_data | input | 9 | Stream data word |
| s_mark | input | 1 | Multi-processor marker for the word |
| txd | output | 1 | Serial output, idle high |

## Verification
The assertions take for granted that `bit_rate` and `len_ext` do not change while a frame is in progress. They also assume that `s_data` and `s_mark` are held steady while `s_valid` waits on `s_ready`. The stimulus changes `bit_rate` and `len_ext` only while the line is idle, before the next word is offered. It drives all inputs half a cycle away from the sampling edge. Mode writes are issued both inside and outside the lock window, and the effect of each write is judged only from the frames that follow it.

// File: rtl/sft_pkg.sv
package sft_pkg;
  typedef struct packed {
    logic       rsvd;
    logic [1:0] clk_sel;
    logic       len_bit;
    logic       mp_en;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } mode_t;
endpackage

// File: rtl/sft_mode_reg.sv
module sft_mode_reg
  import sft_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       tx_en,
  input  logic       rx_en,
  output mode_t      mode
);
  logic open_win;
  assign open_win = ~tx_en & ~rx_en;

  always_ff @(posedge clk) begin
    if (!rst_n)              mode <= '0;
    else if (we && open_win) mode <= mode_t'(wdata);
  end
endmodule

// File: rtl/sft_baud.sv
module sft_baud #(
  parameter int BRC_W = 8,
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       clk_sel,
  input  logic [BRC_W-1:0] bit_rate,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q, pre_lim;
  logic [BRC_W-1:0] cnt_q;
  logic             pre_last;

  always_comb begin
    case (clk_sel)
      2'd0:    pre_lim = PRE_W'(0);
      2'd1:    pre_lim = PRE_W'(3);
      2'd2:    pre_lim = PRE_W'(15);
      default: pre_lim = PRE_W'(63);
    endcase
  end

  assign pre_last = (pre_q == pre_lim);
  assign tick     = run && pre_last && (cnt_q == bit_rate);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (pre_last) begin
      pre_q <= '0;
      cnt_q <= (cnt_q == bit_rate) ? '0 : cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/sft_framer.sv
module sft_framer
  import sft_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_mark,
  input  mode_t             mode,
  input  logic              len_ext,
  input  logic              tick,
  output logic              busy,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int LEN_W   = $clog2(DATA_W + 1);

  logic [FRAME_W-1:0] frame, sh_q;
  logic [CNT_W-1:0]   total, left_q;
  logic [LEN_W-1:0]   dlen;
  logic               has_xb, xbit, dpar, accept;

  always_comb begin
    case ({len_ext, mode.len_bit})
      2'b10:   dlen = LEN_W'(DATA_W - 1);
      2'b11:   dlen = LEN_W'(DATA_W - 2);
      default: dlen = LEN_W'(DATA_W);
    endcase
  end

  always_comb begin
    has_xb = mode.mp_en | mode.par_en;
    dpar   = 1'b0;
    frame  = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(dlen)) begin
        frame[i+1] = s_data[i];
        dpar       = dpar ^ s_data[i];
      end
    end
    xbit = mode.mp_en ? s_mark : (dpar ^ mode.par_odd);
    if (has_xb) frame[dlen + 1'b1] = xbit;
    total = CNT_W'(dlen) + CNT_W'(has_xb) + CNT_W'(mode.stop2) + CNT_W'(2);
  end

  assign s_ready = ~busy & tx_en;
  assign accept  = s_valid & s_ready;
  assign txd     = busy ? sh_q[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      sh_q   <= frame;
      left_q <= total - 1'b1;
    end else if (busy && tick) begin
      if (left_q == '0) begin
        busy <= 1'b0;
      end else begin
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sft_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int BRC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              len_ext,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [BRC_W-1:0]  bit_rate,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_mark,
  output logic              txd
);
  localparam int PRE_W = 6;

  mode_t mode_q;
  logic  busy, tick;

  sft_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .tx_en(tx_en), .rx_en(rx_en), .mode(mode_q)
  );

  sft_baud #(.BRC_W(BRC_W), .PRE_W(PRE_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy), .clk_sel(mode_q.clk_sel),
    .bit_rate(bit_rate), .tick(tick)
  );

  sft_framer #(.DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .s_mark(s_mark), .mode(mode_q),
    .len_ext(len_ext), .tick(tick), .busy(busy), .txd(txd)
  );
endmodule

// File: rtl/sft_checker.sv
module sft_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       tx_en,
  input logic       rx_en,
  input logic       s_valid,
  input logic       s_ready,
  input logic       txd,
  input logic       busy,
  input logic [7:0] mode_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode_q == 8'h00 && !busy && txd));

  // R5
  stop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(txd));

  // R8
  write_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (tx_en || rx_en)) |=> $stable(mode_q));

  // R9
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (tx_en && txd));

  // R9
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !s_ready);

  // R9
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (busy && !txd));
endmodule

bind serial_frame_tx sft_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .tx_en(tx_en), .rx_en(rx_en),
  .s_valid(s_valid), .s_ready(s_ready), .txd(txd), .busy(busy),
  .mode_q(mode_q)
);

// File: tb/serial_frame_tx_bench.sv
module serial_frame_tx_bench;
  localparam int CLK_P = 10;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       len_ext = 1'b1;
  logic       tx_en = 1'b0;
  logic       rx_en = 1'b0;
  logic [7:0] bit_rate = 8'd2;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [8:0] s_data = '0;
  logic       s_mark = 1'b0;
  logic       txd;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  string cur_tag = "R1";
  logic  q[$];
  logic [7:0] m_mode = '0;

  serial_frame_tx u_serial_frame_tx (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .len_ext(len_ext), .tx_en(tx_en), .rx_en(rx_en), .bit_rate(bit_rate),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_mark(s_mark),
    .txd(txd)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push_frame(logic [8:0] d, logic mk);
    int   sel, per, n, ones;
    logic bits[$];
    sel = int'(m_mode[6:5]);
    per = (1 << (2 * sel)) * (int'(bit_rate) + 1);
    case ({len_ext, m_mode[4]})
      2'b10:   n = 8;
      2'b11:   n = 7;
      default: n = 9;
    endcase
    ones = 0;
    bits.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      bits.push_back(d[i]);
      if (d[i]) ones++;
    end
    if (m_mode[3])      bits.push_back(mk);
    else if (m_mode[2]) bits.push_back(((ones % 2) == 1) ^ m_mode[1]);
    bits.push_back(1'b1);
    if (m_mode[0]) bits.push_back(1'b1);
    foreach (bits[b])
      for (int k = 0; k < per; k++) q.push_back(bits[b]);
  endtask

  // reference model, advanced on the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_mode = '0;
    end else begin
      if (q.size() > 0) void'(q.pop_front());
      if (s_valid && s_ready) push_frame(s_data, s_mark);
      if (cfg_we && !tx_en && !rx_en) m_mode = cfg_wdata;
    end
  end

  // compare away from the edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      check(cur_tag, "txd", txd, (q.size() > 0) ? q[0] : 1'b1);
      check(cur_tag, "s_ready", s_ready, (q.size() == 0) && tx_en);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr_mode(logic [7:0] v);
    @(negedge clk);
    tx_en = 1'b0; cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0; tx_en = 1'b1;
  endtask

  task automatic locked_write(logic [7:0] v, logic te, logic re);
    @(negedge clk);
    tx_en = te; rx_en = re; cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0; rx_en = 1'b0; tx_en = 1'b1;
  endtask

  task automatic send(logic [8:0] d, logic mk);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_data = d; s_mark = mk;
    @(negedge clk);
    s_valid = 1'b0; s_data = ~d; s_mark = ~mk;
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R1: idle line and no readiness while disabled
    check("R1", "txd after reset", txd, 1'b1);
    check("R1", "s_ready with tx_en=0", s_ready, 1'b0);
    tx_en = 1'b1;
    cur_tag = "R1"; send(9'h0A5, 1'b0);

    cur_tag = "R3"; len_ext = 1'b0; wr_mode(8'h00); send(9'h1A5, 1'b0);
    cur_tag = "R3"; wr_mode(8'h10); send(9'h0F3, 1'b0);
    cur_tag = "R4"; len_ext = 1'b1; wr_mode(8'h10); send(9'h1FF, 1'b0);
    cur_tag = "R4"; send(9'h155, 1'b0);

    cur_tag = "R2"; bit_rate = 8'd1; wr_mode(8'h20); send(9'h03C, 1'b0);
    cur_tag = "R2"; bit_rate = 8'd0; wr_mode(8'h40); send(9'h0C3, 1'b0);
    cur_tag = "R2"; wr_mode(8'h60); send(9'h081, 1'b0);

    bit_rate = 8'd2;
    cur_tag = "R5"; wr_mode(8'h01); send(9'h07E, 1'b0);
    cur_tag = "R6"; wr_mode(8'h04); send(9'h007, 1'b0);
    cur_tag = "R6"; wr_mode(8'h04); send(9'h003, 1'b0);
    cur_tag = "R6"; wr_mode(8'h06); send(9'h007, 1'b0);
    cur_tag = "R6"; wr_mode(8'h07); send(9'h0F0, 1'b0);

    cur_tag = "R7"; wr_mode(8'h0E); send(9'h007, 1'b1);
    cur_tag = "R7"; send(9'h007, 1'b0);

    cur_tag = "R8"; wr_mode(8'h00);
    locked_write(8'h27, 1'b1, 1'b0); send(9'h0B4, 1'b0);
    locked_write(8'h05, 1'b0, 1'b1); send(9'h04B, 1'b0);

    // R9: valid held across two frames, data swapped on acceptance
    cur_tag = "R9";
    @(negedge clk);
    s_valid = 1'b1; s_data = 9'h0AA;
    @(negedge clk);
    while (s_ready) @(negedge clk);
    s_data = 9'h055;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_data = 9'h1FF;
    while (q.size() != 0) @(negedge clk);
    tx_en = 1'b0;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule